// File: doc/BRIEF.md
# Sector Bit-Flip Corrector

This block takes the error bit positions that a BCH decoder has found for one 512-byte sector and repairs the sector in place in an external byte-wide buffer. Each position comes in codeword bit order. The parity bits of the code come first in that order, and the data bits follow in reverse byte order. A position that lands inside the parity span needs no repair, so it is dropped. Any other position is turned into a byte address and a one-hot bit mask. The addressed byte is then fetched, XORed with the mask and written back.

The caller presents four things and pulses `start`: the count of positions, the position array, the code strength as a nibble count (13, 26 or 52), and the stored ECC bytes read from the spare area. When every stored ECC byte is 0xFF, the page is taken to be erased and the block touches nothing. The block walks the array in index order. When it has finished, `done` is raised for one cycle and the number of bits that were actually flipped is reported.

Top module: `bch_bit_fixer`

## Requirements
- R1: After reset, `done`, `buf_rd` and `buf_wr` are low and `flip_count` is 0.
- R2: A location below 4 × `nibbles` falls in the parity span. It causes no buffer read, no buffer write and no flip.
- R3: Any other location is mapped as follows. Let rel = location − 4 × `nibbles`. The byte address is (4095 − rel) / 8, using integer division, and the bit flipped is rel mod 8, with bit 0 being the least significant bit of the byte.
- R4: Each mapped location takes exactly two cycles. In the first cycle `buf_rd` is high with the byte address. In the next cycle `buf_wr` is high with the same address, and `buf_wdata` equals `buf_rdata` XOR the one-hot mask. `buf_rdata` must be valid in the cycle after the read.
- R5: A location whose rel value is 4096 or more is skipped without any buffer access.
- R6: If all `ECC_BYTES` bytes of `ecc_stored` equal 0xFF, the sector is treated as erased. Nothing is read or written, and `done` comes in the cycle after `start` with `flip_count` 0. If any byte differs from 0xFF, correction runs normally.
- R7: Only the first min(`err_count`, 8) entries are processed, strictly in ascending index order. Entry i occupies bits [13i+12 : 13i] of `err_locs`. Applying the same location twice restores the byte.
- R8: `done` is high for exactly one cycle. `start` is sampled on a clock edge, and `done` is seen L cycles after that edge. L = 1 + 2 × (mapped entries) + 1 × (skipped entries), or L = 1 when the page is erased or the count is 0. At that point `flip_count` equals the number of writes made.
- R9: A `start` that arrives while a run is in progress is ignored.
- R10: The count, locations, nibble count and ECC bytes are captured on the accepted `start`. Changing them later during the run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a correction run (sampled while idle) |
| err_count | input | 4 | Number of error locations supplied |
| err_locs | input | 104 | Eight 13-bit codeword bit locations, entry 0 in the low bits |
| nibbles | input | 6 | Code strength expressed as parity nibbles |
| ecc_stored | input | 112 | Stored ECC bytes, checked for the erased pattern |
| buf_addr | output | 9 | Sector buffer byte address |
| buf_rd | output | 1 | Buffer read strobe, data expected one cycle later |
| buf_rdata | input | 8 | Buffer read data |
| buf_wr | output | 1 | Buffer write strobe |
| buf_wdata | output | 8 | Buffer write data |
| done | output | 1 | One-cycle completion pulse |
| flip_count | output | 4 | Number of bits flipped in the last run |

## Verification
The checker watches every cycle for the following:
- every read is followed by a write to the same address;
- no write happens without a read just before it;
- each write changes exactly one bit of the fetched byte;
- `done` lasts one cycle, and the flip counter grows by one per write;
- the block stays quiet while idle;
- an erased page finishes at once with no flips.

Only the bench's scenarios can show the rest. These include the arithmetic of the address and bit mapping, the parity-span and out-of-range skips at their exact boundaries, truncation of the count and the processing order, the latency formula, and the fact that inputs are frozen once a run has started. The bench sweeps every data-bit position for one strength and strided positions for the other two.

// File: rtl/bch_fix_pkg.sv
package bch_fix_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EVAL  = 2'd1,
        ST_WRITE = 2'd2,
        ST_DONE  = 2'd3
    } fix_state_e;

endpackage

// File: rtl/bch_loc_map.sv
// Converts one codeword bit location into a sector byte address and bit index.
module bch_loc_map #(
    parameter int LOC_W        = 13,
    parameter int NIB_W        = 6,
    parameter int SECTOR_BYTES = 512,
    localparam int ADDR_W      = $clog2(SECTOR_BYTES),
    localparam int DATA_BITS   = SECTOR_BYTES * 8
) (
    input  logic [LOC_W-1:0]  loc,
    input  logic [NIB_W-1:0]  nibbles,
    output logic              hit,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_sel
);
    localparam int EXT_W = ((LOC_W > ADDR_W + 3) ? LOC_W : ADDR_W + 3) + 2;

    logic [EXT_W-1:0] span;
    logic [EXT_W-1:0] rel;
    logic [EXT_W-1:0] rev;

    always_comb begin
        span      = EXT_W'(nibbles) << 2;
        rel       = EXT_W'(loc) - span;
        hit       = (EXT_W'(loc) >= span) && (rel < EXT_W'(DATA_BITS));
        rev       = EXT_W'(DATA_BITS - 1) - rel;
        byte_addr = ADDR_W'(rev >> 3);
        bit_sel   = rel[2:0];
    end

endmodule

// File: rtl/bch_erase_detect.sv
// Flags the erased-page pattern: every stored code byte is 0xFF.
module bch_erase_detect #(
    parameter int ECC_BYTES = 14
) (
    input  logic [ECC_BYTES*8-1:0] code,
    output logic                   erased
);
    logic [ECC_BYTES-1:0] is_ff;

    for (genvar g = 0; g < ECC_BYTES; g++) begin : g_byte
        assign is_ff[g] = (code[g*8 +: 8] == 8'hFF);
    end

    assign erased = &is_ff;

endmodule

// File: rtl/bch_bit_fixer.sv
module bch_bit_fixer
    import bch_fix_pkg::*;
#(
    parameter int MAX_ERR      = 8,
    parameter int LOC_W        = 13,
    parameter int NIB_W        = 6,
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_BYTES    = 14,
    localparam int CNT_W       = $clog2(MAX_ERR + 1),
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic [CNT_W-1:0]         err_count,
    input  logic [MAX_ERR*LOC_W-1:0] err_locs,
    input  logic [NIB_W-1:0]         nibbles,
    input  logic [ECC_BYTES*8-1:0]   ecc_stored,
    output logic [ADDR_W-1:0]        buf_addr,
    output logic                     buf_rd,
    input  logic [7:0]               buf_rdata,
    output logic                     buf_wr,
    output logic [7:0]               buf_wdata,
    output logic                     done,
    output logic [CNT_W-1:0]         flip_count
);
    localparam int IDX_W = (MAX_ERR > 1) ? $clog2(MAX_ERR) : 1;

    typedef struct packed {
        fix_state_e                      state;
        logic [CNT_W-1:0]                idx;
        logic [CNT_W-1:0]                cnt;
        logic [CNT_W-1:0]                flips;
        logic [MAX_ERR-1:0][LOC_W-1:0]   locs;
        logic [NIB_W-1:0]                nib;
        logic [ADDR_W-1:0]               addr;
        logic [2:0]                      bsel;
    } fix_regs_t;

    fix_regs_t r_q, r_d;

    logic                         erased_w;
    logic                         idle_w;
    logic [MAX_ERR-1:0]           map_hit;
    logic [ADDR_W-1:0]            map_addr [MAX_ERR];
    logic [2:0]                   map_bit  [MAX_ERR];
    logic [IDX_W-1:0]             cur;

    bch_erase_detect #(
        .ECC_BYTES (ECC_BYTES)
    ) u_erase (
        .code   (ecc_stored),
        .erased (erased_w)
    );

    for (genvar g = 0; g < MAX_ERR; g++) begin : g_map
        bch_loc_map #(
            .LOC_W        (LOC_W),
            .NIB_W        (NIB_W),
            .SECTOR_BYTES (SECTOR_BYTES)
        ) u_map (
            .loc       (r_q.locs[g]),
            .nibbles   (r_q.nib),
            .hit       (map_hit[g]),
            .byte_addr (map_addr[g]),
            .bit_sel   (map_bit[g])
        );
    end

    assign cur = r_q.idx[IDX_W-1:0];

    always_comb begin
        r_d = r_q;
        unique case (r_q.state)
            ST_IDLE: begin
                if (start) begin
                    for (int i = 0; i < MAX_ERR; i++) begin
                        r_d.locs[i] = err_locs[i*LOC_W +: LOC_W];
                    end
                    r_d.nib   = nibbles;
                    r_d.cnt   = (err_count > CNT_W'(MAX_ERR)) ? CNT_W'(MAX_ERR) : err_count;
                    r_d.idx   = '0;
                    r_d.flips = '0;
                    if (erased_w || (err_count == '0)) begin
                        r_d.state = ST_DONE;
                    end else begin
                        r_d.state = ST_EVAL;
                    end
                end
            end
            ST_EVAL: begin
                if (map_hit[cur]) begin
                    r_d.addr  = map_addr[cur];
                    r_d.bsel  = map_bit[cur];
                    r_d.state = ST_WRITE;
                end else if (r_q.idx + 1'b1 == r_q.cnt) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.idx = r_q.idx + 1'b1;
                end
            end
            ST_WRITE: begin
                r_d.flips = r_q.flips + 1'b1;
                if (r_q.idx + 1'b1 == r_q.cnt) begin
                    r_d.state = ST_DONE;
                end else begin
                    r_d.idx   = r_q.idx + 1'b1;
                    r_d.state = ST_EVAL;
                end
            end
            ST_DONE: begin
                r_d.state = ST_IDLE;
            end
            default: r_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_w     = (r_q.state == ST_IDLE);
    assign buf_rd     = (r_q.state == ST_EVAL) && map_hit[cur];
    assign buf_wr     = (r_q.state == ST_WRITE);
    assign buf_addr   = (r_q.state == ST_WRITE) ? r_q.addr : map_addr[cur];
    assign buf_wdata  = buf_rdata ^ (8'h01 << r_q.bsel);
    assign done       = (r_q.state == ST_DONE);
    assign flip_count = r_q.flips;

endmodule

// File: rtl/bch_bit_fixer_chk.sv
module bch_bit_fixer_chk #(
    parameter int MAX_ERR      = 8,
    parameter int SECTOR_BYTES = 512,
    parameter int ECC_BYTES    = 14,
    localparam int CNT_W       = $clog2(MAX_ERR + 1),
    localparam int ADDR_W      = $clog2(SECTOR_BYTES)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   start,
    input logic                   idle,
    input logic [ECC_BYTES*8-1:0] ecc_stored,
    input logic [ADDR_W-1:0]      buf_addr,
    input logic                   buf_rd,
    input logic [7:0]             buf_rdata,
    input logic                   buf_wr,
    input logic [7:0]             buf_wdata,
    input logic                   done,
    input logic [CNT_W-1:0]       flip_count
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> (!buf_rd && !buf_wr && !done));

    p_rd_then_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd |=> (buf_wr && buf_addr == $past(buf_addr)));

    p_wr_after_rd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> $past(buf_rd));

    p_single_flip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |-> ($countones(buf_wdata ^ buf_rdata) == 1));

    p_erased_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && idle && (&ecc_stored)) |=> (done && flip_count == '0));

    p_flip_bound_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flip_count <= CNT_W'(MAX_ERR));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_flip_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
        buf_wr |=> (flip_count == $past(flip_count) + 1'b1));

endmodule

bind bch_bit_fixer bch_bit_fixer_chk #(
    .MAX_ERR      (MAX_ERR),
    .SECTOR_BYTES (SECTOR_BYTES),
    .ECC_BYTES    (ECC_BYTES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .idle       (idle_w),
    .ecc_stored (ecc_stored),
    .buf_addr   (buf_addr),
    .buf_rd     (buf_rd),
    .buf_rdata  (buf_rdata),
    .buf_wr     (buf_wr),
    .buf_wdata  (buf_wdata),
    .done       (done),
    .flip_count (flip_count)
);

// File: tb/bch_bit_fixer_tb_top.sv
`timescale 1ns/1ps
module bch_bit_fixer_tb_top;
    localparam int MAXE  = 8;
    localparam int LW    = 13;
    localparam int NB    = 512;
    localparam int EB    = 14;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [3:0]        err_count = '0;
    logic [MAXE*LW-1:0] err_locs = '0;
    logic [5:0]        nibbles = '0;
    logic [EB*8-1:0]   ecc_stored = '0;
    logic [8:0]        buf_addr;
    logic              buf_rd;
    logic [7:0]        buf_rdata = '0;
    logic              buf_wr;
    logic [7:0]        buf_wdata;
    logic              done;
    logic [3:0]        flip_count;

    int checks = 0;
    int errors = 0;

    logic [7:0] mem [NB];
    int         exp_mem [NB];
    int         locs [MAXE];
    int         cnt_in;
    int         nib_in;
    logic [EB*8-1:0] ecc_in;

    always #2.5 clk = ~clk;

    bch_bit_fixer dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .err_count  (err_count),
        .err_locs   (err_locs),
        .nibbles    (nibbles),
        .ecc_stored (ecc_stored),
        .buf_addr   (buf_addr),
        .buf_rd     (buf_rd),
        .buf_rdata  (buf_rdata),
        .buf_wr     (buf_wr),
        .buf_wdata  (buf_wdata),
        .done       (done),
        .flip_count (flip_count)
    );

    always @(posedge clk) begin
        if (buf_rd) buf_rdata <= mem[buf_addr];
        if (buf_wr) mem[buf_addr] <= buf_wdata;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Runs one correction; hold>0 keeps start high with altered inputs for
    // that many cycles after acceptance (R9, R10).
    task automatic run_case(input string req, input int hold);
        int eff, exp_lat, exp_fl, lat, writes, span, rel, bad;
        bit erased;
        erased = 1'b1;
        for (int b = 0; b < EB; b++) if (ecc_in[b*8 +: 8] != 8'hFF) erased = 1'b0;
        eff = (cnt_in > MAXE) ? MAXE : cnt_in;
        exp_lat = 1;
        exp_fl = 0;
        span = nib_in * 4;
        if (!erased && eff > 0) begin
            for (int i = 0; i < eff; i++) begin
                if (locs[i] >= span && (locs[i] - span) < NB * 8) begin
                    rel = locs[i] - span;
                    exp_mem[(NB * 8 - 1 - rel) / 8] ^= (1 << (rel % 8));
                    exp_fl++;
                    exp_lat += 2;
                end else begin
                    exp_lat += 1;
                end
            end
        end
        @(negedge clk);
        for (int i = 0; i < MAXE; i++) err_locs[i*LW +: LW] = LW'(locs[i]);
        err_count  = 4'(cnt_in);
        nibbles    = 6'(nib_in);
        ecc_stored = ecc_in;
        start      = 1'b1;
        lat = 0;
        writes = 0;
        while (lat < 40) begin
            @(negedge clk);
            lat++;
            if (lat <= hold) begin
                start = 1'b1;
                for (int i = 0; i < MAXE; i++) err_locs[i*LW +: LW] = LW'(span + 17 * i + lat);
                err_count = 4'd1;
                nibbles = 6'd13;
            end else begin
                start = 1'b0;
            end
            if (buf_wr) writes++;
            if (done) break;
        end
        start = 1'b0;
        chk(done === 1'b1 && lat == exp_lat, "R8", "done latency", lat, exp_lat);
        chk(flip_count == 4'(exp_fl), "R8", "flip_count", int'(flip_count), exp_fl);
        chk(writes == exp_fl, {req, "/R4"}, "write strobes", writes, exp_fl);
        bad = -1;
        for (int a = 0; a < NB; a++) if (int'(mem[a]) != exp_mem[a] && bad < 0) bad = a;
        chk(bad < 0, {req, "/R3"}, "buffer content mismatch at byte", bad,
            (bad < 0) ? 0 : exp_mem[bad]);
        @(negedge clk);
        chk(done === 1'b0, "R8", "done width", int'(done), 0);
    endtask

    task automatic clear_locs();
        for (int i = 0; i < MAXE; i++) locs[i] = 0;
        ecc_in = '0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < NB; a++) begin
            mem[a] = 8'((a * 37 + 5) & 8'hFF);
            exp_mem[a] = (a * 37 + 5) & 255;
        end
        clear_locs();
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(done === 1'b0 && buf_rd === 1'b0 && buf_wr === 1'b0 && flip_count == 4'd0,
            "R1", "reset outputs", int'({done, buf_rd, buf_wr}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done === 1'b0 && flip_count == 4'd0, "R1", "idle after reset", int'(done), 0);

        // R3: every data bit for the 26-nibble strength
        for (int r = 0; r < NB * 8; r++) begin
            clear_locs();
            nib_in = 26; cnt_in = 1; locs[0] = 104 + r;
            run_case("R3", 0);
        end
        // R3: strided sweep for the other strengths
        for (int r = 0; r < NB * 8; r += 7) begin
            clear_locs();
            nib_in = 13; cnt_in = 1; locs[0] = 52 + r;
            run_case("R3", 0);
            clear_locs();
            nib_in = 52; cnt_in = 1; locs[0] = 208 + r;
            run_case("R3", 0);
        end

        // R2: parity-span boundary and location zero
        for (int n = 13; n <= 52; n += 13) begin
            clear_locs();
            nib_in = n; cnt_in = 2; locs[0] = n * 4 - 1; locs[1] = 0;
            run_case("R2", 0);
        end
        // R5: past the data span
        clear_locs();
        nib_in = 26; cnt_in = 3; locs[0] = 104 + 4096; locs[1] = 8191; locs[2] = 104 + 4095;
        run_case("R5", 0);

        // R7: mixed list, duplicate restores byte, ordering
        clear_locs();
        nib_in = 26; cnt_in = 8;
        locs[0] = 110; locs[1] = 50; locs[2] = 110; locs[3] = 4000;
        locs[4] = 300; locs[5] = 5000; locs[6] = 301; locs[7] = 103;
        run_case("R7", 0);
        // R7: count above eight is clamped
        clear_locs();
        nib_in = 13; cnt_in = 12;
        for (int i = 0; i < MAXE; i++) locs[i] = 60 + 11 * i;
        run_case("R7", 0);
        // R7: count three of eight valid entries
        clear_locs();
        nib_in = 13; cnt_in = 3;
        for (int i = 0; i < MAXE; i++) locs[i] = 900 + 3 * i;
        run_case("R7", 0);
        // R8: zero count
        clear_locs();
        nib_in = 13; cnt_in = 0; locs[0] = 500;
        run_case("R8", 0);

        // R6: erased page, then one byte not 0xFF
        clear_locs();
        nib_in = 26; cnt_in = 4; locs[0] = 200; locs[1] = 300; locs[2] = 400; locs[3] = 500;
        ecc_in = '1;
        run_case("R6", 0);
        for (int b = 0; b < EB; b += 13) begin
            ecc_in = '1;
            ecc_in[b*8 +: 8] = 8'hFE;
            run_case("R6", 0);
        end

        // R9 and R10: start held and inputs changed during a run
        clear_locs();
        nib_in = 26; cnt_in = 3; locs[0] = 150; locs[1] = 2000; locs[2] = 3500;
        run_case("R9/R10", 2);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule